// File: doc/BRIEF.md
# PWM Output Mask and Stop Gating Stage

This block sits between six raw PWM generator outputs and the output pins. Each channel can be masked, which holds it at 0 percent duty. Each pair of channels can have its polarity inverted. All channels can be forced to their inactive level while the chip is in a low-power wait state or a debug halt, but only when the matching stop bit is set. Pulse generation, dead-time insertion and fault handling are done elsewhere.

Mask updates can be made to wait for a commutation strobe. When this buffering is enabled, a new mask written by software is held in a buffer. The outputs change only at a commutation strobe, so that a motor commutation step happens at one known instant. A write-once protection bit locks the configuration after start-up. The inversion bits stay writable after the lock.

Software reaches the block through a small register port. Writes are synchronous. Read data is combinational from the address.

Top module: `pwm_out_gate`

## Requirements
- R1: Mask bit c (register address 1, bit c) set forces channel c to logic 0 before inversion. Mask bit c clear passes `pwm_raw_i[c]` through unchanged.
- R2: With buffering off (control bit 0 clear), a mask write takes effect at the clock edge that captures it. `pwm_o` shows the new mask right after that edge.
- R3: With buffering on, a written mask goes only into the buffer. The active mask loads the buffer at each clock edge where `commut_i` is high and holds at every other edge. If a write and a strobe arrive in the same cycle, the strobe loads the value that was buffered before that write, and the new value waits for the next strobe.
- R4: Reading address 1 returns the buffered mask in bits 5:0 and zeros above them. This value can differ from the mask applied to the outputs.
- R5: The configuration register is at address 0. Its fields are: bit 7 wait-stop, bit 6 freeze-stop, bit 5 reserved (always reads 0), bits 4:3 a stored mode field with no effect on the outputs, and bits 2:0 the inversion bits for pair C (channels 5,4), pair B (channels 3,2) and pair A (channels 1,0). Every register resets to 0. Address 3 reads 0.
- R6: A set inversion bit inverts both channels of its pair, after masking.
- R7: While `wait_mode_i` is high and wait-stop is 1, every output sits at its inactive level: 0 for a non-inverted pair, 1 for an inverted one. Normal operation resumes as soon as `wait_mode_i` falls. When wait-stop is 0, wait mode has no effect.
- R8: Freeze-stop and `freeze_mode_i` behave the same way as wait-stop and `wait_mode_i` in R7.
- R9: The control register is at address 2: bit 0 enables buffering and bit 1 is write protection. Protection can be set but is cleared only by reset. Once it is set, writes leave configuration bits 7:3 and the buffering bit unchanged. The inversion bits and the mask stay writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pwm_raw_i | input | 6 | Raw PWM generator outputs |
| commut_i | input | 1 | Commutation strobe |
| wait_mode_i | input | 1 | Chip is in wait mode |
| freeze_mode_i | input | 1 | Chip is in freeze (debug) mode |
| pwm_o | output | 6 | Gated PWM outputs |

## Verification
The active mask is stored apart from the buffer that software reads. If the two become inconsistent, the fault shows up at `pwm_o` rather than at `rdata_o`. A strobe that arrives too early or too late, or not at all, changes the outputs one cycle away from the expected edge. The bench therefore samples the outputs both before and after each strobe edge. A protection latch that leaks shows up on the next read-back of the configuration or control register. A stop-gating fault is visible at once on the combinational outputs, in the same cycle the mode input changes.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned INV_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG  = 2'd0,
    REG_MASK = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             wait_stop;
    logic             frz_stop;
    logic             rsv;
    logic [1:0]       mode;
    logic [INV_W-1:0] inv;
  } cfg_t;

  // writable bits of the config register (reserved bit forced low)
  localparam logic [DATA_W-1:0] CFG_WMASK = 8'hDF;
  localparam int unsigned CTRL_ENCE_BIT = 0;
  localparam int unsigned CTRL_WP_BIT   = 1;
endpackage

// File: rtl/pwm_gate_regs.sv
module pwm_gate_regs
  import pwm_gate_pkg::*;
#(
  parameter int unsigned N_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_CH-1:0]   mask_buf_i,
  output cfg_t              cfg_o,
  output logic              ence_o,
  output logic              wp_o,
  output logic              mask_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - N_CH;

  cfg_t cfg_q, cfg_d;
  logic ence_q, ence_d;
  logic wp_q, wp_d;
  logic [DATA_W-1:0] wclean;
  reg_addr_e sel;

  assign sel    = reg_addr_e'(addr_i);
  assign wclean = wdata_i & CFG_WMASK;

  always_comb begin
    cfg_d  = cfg_q;
    ence_d = ence_q;
    wp_d   = wp_q;
    if (wr_i && sel == REG_CFG) begin
      if (wp_q) cfg_d.inv = wclean[INV_W-1:0];
      else      cfg_d     = cfg_t'(wclean);
    end
    if (wr_i && sel == REG_CTRL) begin
      if (!wp_q) ence_d = wdata_i[CTRL_ENCE_BIT];
      if (wdata_i[CTRL_WP_BIT]) wp_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      ence_q <= 1'b0;
      wp_q   <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      ence_q <= ence_d;
      wp_q   <= wp_d;
    end
  end

  always_comb begin
    unique case (sel)
      REG_CFG:  rdata_o = cfg_q;
      REG_MASK: rdata_o = {{PAD_W{1'b0}}, mask_buf_i};
      REG_CTRL: rdata_o = {{(DATA_W-2){1'b0}}, wp_q, ence_q};
      default:  rdata_o = '0;
    endcase
  end

  assign mask_wr_o = wr_i && sel == REG_MASK;
  assign cfg_o     = cfg_q;
  assign ence_o    = ence_q;
  assign wp_o      = wp_q;
endmodule

// File: rtl/pwm_gate_mask.sv
module pwm_gate_mask #(
  parameter int unsigned N_CH = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ence_i,
  input  logic            commut_i,
  input  logic            wr_i,
  input  logic [N_CH-1:0] wdata_i,
  output logic [N_CH-1:0] buf_o,
  output logic [N_CH-1:0] act_o
);
  logic [N_CH-1:0] buf_q, buf_d, act_q, act_d;

  always_comb begin
    buf_d = wr_i ? wdata_i : buf_q;
    if (ence_i) act_d = commut_i ? buf_q : act_q;  // strobe loads pre-write buffer
    else        act_d = buf_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;
endmodule

// File: rtl/pwm_gate_out.sv
module pwm_gate_out #(
  parameter int unsigned N_CH    = 6,
  parameter int unsigned N_PAIRS = N_CH / 2
) (
  input  logic [N_CH-1:0]    raw_i,
  input  logic [N_CH-1:0]    mask_i,
  input  logic [N_PAIRS-1:0] inv_i,
  input  logic               stop_i,
  output logic [N_CH-1:0]    pwm_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic gated;
    assign gated    = stop_i ? 1'b0 : (raw_i[c] & ~mask_i[c]);
    assign pwm_o[c] = gated ^ inv_i[c/2];
  end
endmodule

// File: rtl/pwm_out_gate.sv
module pwm_out_gate
  import pwm_gate_pkg::*;
#(
  parameter int unsigned N_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_CH-1:0]   pwm_raw_i,
  input  logic              commut_i,
  input  logic              wait_mode_i,
  input  logic              freeze_mode_i,
  output logic [N_CH-1:0]   pwm_o
);
  localparam int unsigned N_PAIRS = N_CH / 2;

  cfg_t            cfg_q;
  logic            ence_q, wp_q, mask_wr, stop;
  logic [N_CH-1:0] mask_buf, mask_act;

  pwm_gate_regs #(.N_CH(N_CH)) regs_i (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .mask_buf_i(mask_buf),
    .cfg_o(cfg_q), .ence_o(ence_q), .wp_o(wp_q),
    .mask_wr_o(mask_wr), .rdata_o
  );

  pwm_gate_mask #(.N_CH(N_CH)) mask_i (
    .clk_i, .rst_ni,
    .ence_i(ence_q), .commut_i,
    .wr_i(mask_wr), .wdata_i(wdata_i[N_CH-1:0]),
    .buf_o(mask_buf), .act_o(mask_act)
  );

  assign stop = (wait_mode_i & cfg_q.wait_stop) | (freeze_mode_i & cfg_q.frz_stop);

  pwm_gate_out #(.N_CH(N_CH), .N_PAIRS(N_PAIRS)) out_i (
    .raw_i(pwm_raw_i), .mask_i(mask_act),
    .inv_i(cfg_q.inv[N_PAIRS-1:0]), .stop_i(stop), .pwm_o
  );
endmodule

// File: rtl/pwm_out_gate_chk.sv
module pwm_out_gate_chk
  import pwm_gate_pkg::*;
#(
  parameter int unsigned N_CH = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_CH-1:0]   wdata_i,
  input logic              commut_i,
  input logic              wait_mode_i,
  input logic              freeze_mode_i,
  input logic [N_CH-1:0]   pwm_o,
  input logic [DATA_W-1:0] cfg_i,
  input logic              ence_i,
  input logic              wp_i,
  input logic [N_CH-1:0]   mask_buf_i,
  input logic [N_CH-1:0]   mask_act_i,
  input logic              stop_i
);
  logic [N_CH-1:0] inv_vec;
  for (genvar c = 0; c < N_CH; c++) begin : g_inv
    assign inv_vec[c] = cfg_i[c/2];
  end

  p_mask_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |-> ((pwm_o ^ inv_vec) & mask_act_i) == '0);

  p_direct_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ence_i && wr_i && addr_i == REG_MASK) |=> mask_act_i == $past(wdata_i));

  p_buf_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ence_i && !commut_i) |=> $stable(mask_act_i));

  p_buf_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ence_i && commut_i) |=> mask_act_i == $past(mask_buf_i));

  p_wait_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_mode_i && cfg_i[7]) |-> pwm_o == inv_vec);

  p_frz_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_mode_i && cfg_i[6]) |-> pwm_o == inv_vec);

  p_wp_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |=> wp_i);

  p_cfg_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |=> ($stable(cfg_i[7:3]) && $stable(ence_i)));
endmodule

bind pwm_out_gate pwm_out_gate_chk #(.N_CH(N_CH)) chk_i (
  .clk_i, .rst_ni, .wr_i, .addr_i,
  .wdata_i(wdata_i[N_CH-1:0]),
  .commut_i, .wait_mode_i, .freeze_mode_i, .pwm_o,
  .cfg_i(cfg_q), .ence_i(ence_q), .wp_i(wp_q),
  .mask_buf_i(mask_buf), .mask_act_i(mask_act), .stop_i(stop)
);

// File: tb/pwm_out_gate_tb_top.sv
module pwm_out_gate_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [5:0] pwm_raw_i = '0;
  logic       commut_i = 1'b0;
  logic       wait_mode_i = 1'b0;
  logic       freeze_mode_i = 1'b0;
  logic [5:0] pwm_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwm_out_gate #(.N_CH(6)) dut_i (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .pwm_raw_i, .commut_i, .wait_mode_i, .freeze_mode_i, .pwm_o
  );

  function automatic logic [5:0] exp_pwm(input logic [5:0] raw, input logic [5:0] m,
                                         input logic [2:0] inv, input bit stop);
    logic [5:0] r;
    for (int c = 0; c < 6; c++) begin
      r[c] = (stop ? 1'b0 : (raw[c] & ~m[c])) ^ inv[c/2];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic pwm_chk(input string req, input logic [5:0] exp);
    #1;
    chk(req, {2'b00, pwm_o}, {2'b00, exp});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] raws [4];
    raws[0] = 6'h00; raws[1] = 6'h3F; raws[2] = 6'h15; raws[3] = 6'h2A;

    pwm_raw_i = 6'h2D;
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    // R5 reset state
    rd_chk("R5 cfg reset", 2'd0, 8'h00);
    rd_chk("R4 mask reset", 2'd1, 8'h00);
    rd_chk("R9 ctrl reset", 2'd2, 8'h00);
    rd_chk("R5 addr3", 2'd3, 8'h00);
    pwm_chk("R1 reset pass", 6'h2D);

    // R1/R2/R4: every mask with buffering off
    for (int m = 0; m < 64; m++) begin
      wr(2'd1, 8'(m));
      for (int k = 0; k < 4; k++) begin
        pwm_raw_i = raws[k];
        pwm_chk("R1 R2 mask sweep", exp_pwm(raws[k], 6'(m), 3'b000, 1'b0));
      end
      rd_chk("R4 mask read", 2'd1, 8'(m));
    end

    // R6: every inversion setting against every raw input
    wr(2'd1, 8'h09);
    for (int v = 0; v < 8; v++) begin
      wr(2'd0, 8'(v));
      for (int r = 0; r < 64; r++) begin
        pwm_raw_i = 6'(r);
        pwm_chk("R6 inversion", exp_pwm(6'(r), 6'h09, 3'(v), 1'b0));
      end
    end

    // R5 reserved bit, mode field stored
    wr(2'd0, 8'h38);
    rd_chk("R5 rsv reads 0", 2'd0, 8'h18);

    // R7/R8: stop bits x mode inputs
    pwm_raw_i = 6'h3A;
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, {s[1], s[0], 3'b000, 3'b101});
      for (int md = 0; md < 4; md++) begin
        wait_mode_i = md[1]; freeze_mode_i = md[0];
        pwm_chk("R7 R8 stop gating",
                exp_pwm(6'h3A, 6'h09, 3'b101, (md[1] & s[1]) | (md[0] & s[0])));
      end
      wait_mode_i = 1'b0; freeze_mode_i = 1'b0;
      pwm_chk("R7 R8 resume", exp_pwm(6'h3A, 6'h09, 3'b101, 1'b0));
    end

    // R3: buffered mask
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h05);
    pwm_raw_i = 6'h3F;
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h30);
    pwm_chk("R3 write held", 6'h3A);
    rd_chk("R4 read buffer", 2'd1, 8'h30);
    repeat (3) @(negedge clk_i);
    pwm_chk("R3 still held", 6'h3A);
    commut_i = 1'b1;
    pwm_chk("R3 before strobe edge", 6'h3A);
    @(negedge clk_i);
    commut_i = 1'b0;
    pwm_chk("R3 after strobe", 6'h0F);
    wr(2'd1, 8'h11);
    pwm_chk("R3 held 2", 6'h0F);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 2'd1; wdata_i = 8'h22; commut_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; commut_i = 1'b0;
    pwm_chk("R3 same-cycle loads old buffer", 6'h2E);
    rd_chk("R4 new buffer", 2'd1, 8'h22);
    commut_i = 1'b1;
    @(negedge clk_i);
    commut_i = 1'b0;
    pwm_chk("R3 next strobe", 6'h1D);

    // R9: write protection
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h1A);
    wr(2'd2, 8'h03);
    rd_chk("R9 ctrl set", 2'd2, 8'h03);
    wr(2'd0, 8'hC5);
    rd_chk("R9 cfg locked inv free", 2'd0, 8'h1D);
    wr(2'd2, 8'h00);
    rd_chk("R9 wp sticky ence locked", 2'd2, 8'h03);
    wr(2'd1, 8'h07);
    rd_chk("R9 mask writable", 2'd1, 8'h07);
    pwm_raw_i = 6'h3F;
    wait_mode_i = 1'b1; freeze_mode_i = 1'b1;
    pwm_chk("R9 stop bits stayed clear", exp_pwm(6'h3F, 6'h22, 3'b101, 1'b0));
    wait_mode_i = 1'b0; freeze_mode_i = 1'b0;
    commut_i = 1'b1;
    @(negedge clk_i);
    commut_i = 1'b0;
    pwm_chk("R9 buffering still on", exp_pwm(6'h3F, 6'h07, 3'b101, 1'b0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule